// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frames from memory to a byte stream. Software places 8-byte buffer descriptors in a ring, marks them ready and pulses a kick strobe. The engine then walks the ring through a word-wide memory master port. For each ready descriptor it reads the header and the buffer pointer, fetches the buffer bytes, streams them out, and writes the header back with the ready flag cleared. A frame may span several chained descriptors. The frame ends at the descriptor that carries the last flag.

The stream uses a valid/ready handshake and marks the final byte of each frame with `tx_last`. To do this, one byte is always held back until the engine knows whether another byte follows. Three single-cycle event pulses feed the interrupt logic: one per retired descriptor, one per completed frame, and one when a frame is clipped at the byte cap. A partly built frame stays open across kicks. A frame with no bytes at all raises its events but sends nothing on the stream.

The ring base register must not be written while a pass is running.

Top module: `txring_engine`

## Requirements
- R1: A descriptor is two big-endian words. At the descriptor address, bits 31:16 are the flags and bits 15:0 are the byte length. At address+4 is the 32-bit buffer address. The buffer byte at address a sits in lane a[1:0] of the word at a with the low two bits cleared, where lane 0 is bits 31:24 and lane 3 is bits 7:0.
- R2: A pass stops at the first descriptor whose flag bit 15 (ready) is clear. That descriptor is not written back, and the current pointer keeps pointing at it.
- R3: The buffer bytes of consecutive descriptors appear on the stream in order, with nothing lost or repeated. `tx_last` is high only on the final byte of the descriptor whose flag bit 11 (last) is set.
- R4: Each consumed descriptor is written back with flag bit 15 cleared and every other bit unchanged. It raises `evt_txbuf` once. When its flag bit 11 is set it also raises `evt_txframe` once.
- R5: After a descriptor is retired, the current pointer moves to the ring base if flag bit 13 (wrap) is set, and to the current address plus 8 otherwise.
- R6: A frame carries at most FRAME_CAP bytes (default 2032). Bytes beyond the cap are dropped, and `evt_babble` pulses once for each descriptor that was clipped.
- R7: One kick retires at most MAX_DESC descriptors (default 1024). The next kick continues from the current pointer.
- R8: A kick has no effect while `enable` is low.
- R9: Writing the ring base stores the written value with bits 1:0 forced to zero. The same write sets the current pointer to that value.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R11: A kick that arrives while a pass is running is remembered. A second pass runs after the current one ends.
- R12: A memory request keeps its address, direction and write data until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enable; kicks count only while high |
| kick | input | 1 | Transmit kick strobe |
| base_we | input | 1 | Ring base write strobe |
| base_wdata | input | 32 | Ring base write value |
| ring_base | output | 32 | Current ring base |
| cur_ptr | output | 32 | Address of the next descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Stream sink ready |
| evt_txbuf | output | 1 | Descriptor retired pulse |
| evt_txframe | output | 1 | Frame completed pulse |
| evt_babble | output | 1 | Frame clipped pulse |

## Verification
The walker is tested with five kinds of ring:
- **A single aligned buffer.** This shows basic fetch, write-back and stop behaviour.
- **A three-descriptor chain.** It uses unaligned buffers, a zero-length middle buffer and a wrap flag. This separates correct lane selection and `tx_last` placement from off-by-one byte handling, and plus-8 stepping from wrapping.
- **A frame that crosses the cap.** This shows that clipping happens at the exact byte count and that the babble event follows it.
- **A ring of one-byte frames longer than the per-kick limit.** This separates the limit from the not-ready stop.
- **A second kick during a busy pass.** Because the descriptor reads are counted, this proves that the latched kick triggers exactly one extra header read.

Throughout, sink back-pressure and memory latency are random.

// File: rtl/txr_pkg.sv
// Package: shared constants and the state type of the transmit ring walker.
// Assumes 32-bit words and the two-word descriptor layout described in the brief.
package txr_pkg;
    localparam int WORD_W      = 32;
    localparam int HALF_W      = 16;
    localparam int DESC_STRIDE = 8;
    localparam int FLG_READY   = 15;
    localparam int FLG_WRAP    = 13;
    localparam int FLG_LAST    = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PTR,
        ST_BYTES,
        ST_CLOSE,
        ST_RETIRE
    } txr_state_e;
endpackage

// File: rtl/txr_ring_ptr.sv
// Module: holds the ring base and the current descriptor pointer.
// A base write aligns the value to a word and also reloads the pointer.
// A step either wraps to the base or advances by one descriptor stride.
// A base write wins over a step in the same cycle.
module txr_ring_ptr
    import txr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          step,
    input  logic          step_wrap,
    output logic [AW-1:0] ring_base,
    output logic [AW-1:0] cur_ptr
);
    localparam logic [AW-1:0] STRIDE = AW'(DESC_STRIDE);

    // Update the base register and the walking pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_base <= '0;
            cur_ptr   <= '0;
        end else if (base_we) begin
            ring_base <= {base_wdata[AW-1:2], 2'b00};
            cur_ptr   <= {base_wdata[AW-1:2], 2'b00};
        end else if (step) begin
            cur_ptr <= step_wrap ? ring_base : cur_ptr + STRIDE;
        end
    end

    // R9
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> (cur_ptr == {$past(base_wdata[AW-1:2]), 2'b00}) && (ring_base == cur_ptr));
endmodule

// File: rtl/txr_word_cache.sv
// Module: keeps the most recently fetched buffer word and its tag.
// Picks out one byte by address lane, with lane 0 as the most significant byte.
// It is invalidated whenever a new descriptor is loaded, so stale memory is never reused.
module txr_word_cache
    import txr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval,
    input  logic              fill,
    input  logic [AW-1:0]     fill_addr,
    input  logic [WORD_W-1:0] fill_data,
    input  logic [AW-1:0]     look_addr,
    output logic              hit,
    output logic [7:0]        byte_out
);
    localparam int LANES = WORD_W / 8;

    logic              vld_q;
    logic [AW-3:0]     tag_q;
    logic [WORD_W-1:0] word_q;
    logic [7:0]        lane_b [LANES];

    // Capture a fetched word or drop the cached one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            tag_q  <= '0;
            word_q <= '0;
        end else if (inval) begin
            vld_q <= 1'b0;
        end else if (fill) begin
            vld_q  <= 1'b1;
            tag_q  <= fill_addr[AW-1:2];
            word_q <= fill_data;
        end
    end

    // Split the word into big-endian byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = word_q[WORD_W-1-8*g -: 8];
    end

    // Report a hit and select the addressed lane.
    always_comb begin
        hit      = vld_q && (tag_q == look_addr[AW-1:2]);
        byte_out = lane_b[look_addr[1:0]];
    end
endmodule

// File: rtl/txr_hold_stage.sv
// Module: a one-byte hold-back followed by the output register of the stream.
// A byte is released to the output only when its successor arrives.
// A close request instead releases the held byte with the last marker set.
// Assumes the producer does not offer a byte and request a close in the same cycle.
module txr_hold_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    input  logic       close_req,
    output logic       close_ack,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last,
    input  logic       tx_ready
);
    logic       hv_q;
    logic [7:0] hb_q;
    logic       out_free;

    // Work out when the output slot is free and when a close can finish.
    always_comb begin
        out_free  = !tx_valid || tx_ready;
        in_ready  = !hv_q || out_free;
        close_ack = close_req && (!hv_q || out_free);
    end

    // Move bytes from the hold slot into the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv_q     <= 1'b0;
            hb_q     <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_last  <= 1'b0;
        end else begin
            if (tx_valid && tx_ready) tx_valid <= 1'b0;
            if (in_valid && in_ready) begin
                if (hv_q) begin
                    tx_valid <= 1'b1;
                    tx_data  <= hb_q;
                    tx_last  <= 1'b0;
                end
                hb_q <= in_byte;
                hv_q <= 1'b1;
            end else if (close_req && hv_q && out_free) begin
                tx_valid <= 1'b1;
                tx_data  <= hb_q;
                tx_last  <= 1'b1;
                hv_q     <= 1'b0;
            end
        end
    end

    // R10
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
endmodule

// File: rtl/txring_engine.sv
// Module: the transmit descriptor ring walker (top level).
// Once kicked, it reads each descriptor, streams that buffer's bytes, and writes the header back with the ready flag cleared.
// A pass ends at the first descriptor that is not ready, or after MAX_DESC descriptors.
// Assumes the memory port acknowledges each request exactly once.
// Assumes the ring base is not written during a pass.
module txring_engine
    import txr_pkg::*;
#(
    parameter int FRAME_CAP = 2032,
    parameter int MAX_DESC  = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        kick,
    input  logic        base_we,
    input  logic [31:0] base_wdata,
    output logic [31:0] ring_base,
    output logic [31:0] cur_ptr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        evt_txbuf,
    output logic        evt_txframe,
    output logic        evt_babble
);
    localparam int AW     = 32;
    localparam int LEN_W  = HALF_W;
    localparam int FCNT_W = $clog2(FRAME_CAP + 1);
    localparam int DCNT_W = $clog2(MAX_DESC + 1);

    txr_state_e          state_q;
    logic                pend_q;
    logic [HALF_W-1:0]   flags_q;
    logic [LEN_W-1:0]    len_q;
    logic [AW-1:0]       bufp_q;
    logic [LEN_W-1:0]    take_q;
    logic [LEN_W-1:0]    idx_q;
    logic [FCNT_W-1:0]   fcnt_q;
    logic [DCNT_W-1:0]   dcnt_q;

    logic                go;
    logic                done;
    logic [AW-1:0]       byte_addr;
    logic [LEN_W-1:0]    room;
    logic                hit;
    logic [7:0]          cache_byte;
    logic                in_valid;
    logic                in_ready;
    logic                close_req;
    logic                close_ack;
    logic                step;
    logic                inval;
    logic                fill;

    // Decode conditions that depend on the current state.
    always_comb begin
        go        = (state_q == ST_IDLE) && (pend_q || (kick && enable));
        done      = (idx_q == take_q);
        byte_addr = bufp_q + AW'(idx_q);
        room      = LEN_W'(FRAME_CAP) - LEN_W'(fcnt_q);
        in_valid  = (state_q == ST_BYTES) && !done && hit;
        close_req = (state_q == ST_CLOSE);
        step      = (state_q == ST_RETIRE) && mem_ack;
        inval     = (state_q == ST_PTR) && mem_ack;
        fill      = (state_q == ST_BYTES) && mem_ack;
    end

    // Drive the memory master port from the state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = '0;
        case (state_q)
            ST_HDR: mem_req = 1'b1;
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + 32'd4;
            end
            ST_BYTES: begin
                mem_req  = !done && !hit;
                mem_addr = {byte_addr[AW-1:2], 2'b00};
            end
            ST_RETIRE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {flags_q & ~(HALF_W'(1) << FLG_READY), len_q};
            end
            default: mem_req = 1'b0;
        endcase
    end

    // Remember a kick that arrives while a pass is already running.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  pend_q <= 1'b0;
        else if (go)                                 pend_q <= 1'b0;
        else if (kick && enable && state_q != ST_IDLE) pend_q <= 1'b1;
    end

    // Main sequencer: header, pointer, bytes, close, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            flags_q     <= '0;
            len_q       <= '0;
            bufp_q      <= '0;
            take_q      <= '0;
            idx_q       <= '0;
            fcnt_q      <= '0;
            dcnt_q      <= '0;
            evt_txbuf   <= 1'b0;
            evt_txframe <= 1'b0;
            evt_babble  <= 1'b0;
        end else begin
            evt_txbuf   <= 1'b0;
            evt_txframe <= 1'b0;
            evt_babble  <= 1'b0;
            case (state_q)
                ST_IDLE: if (go) begin
                    dcnt_q  <= '0;
                    state_q <= ST_HDR;
                end
                ST_HDR: if (mem_ack) begin
                    flags_q <= mem_rdata[31:16];
                    len_q   <= mem_rdata[15:0];
                    state_q <= mem_rdata[16+FLG_READY] ? ST_PTR : ST_IDLE;
                end
                ST_PTR: if (mem_ack) begin
                    bufp_q <= mem_rdata;
                    idx_q  <= '0;
                    if (len_q > room) begin
                        take_q     <= room;
                        evt_babble <= 1'b1;
                    end else begin
                        take_q <= len_q;
                    end
                    state_q <= ST_BYTES;
                end
                ST_BYTES: begin
                    if (in_valid && in_ready) begin
                        idx_q  <= idx_q + 1'b1;
                        fcnt_q <= fcnt_q + 1'b1;
                    end
                    if (done) state_q <= flags_q[FLG_LAST] ? ST_CLOSE : ST_RETIRE;
                end
                ST_CLOSE: if (close_ack) begin
                    fcnt_q  <= '0;
                    state_q <= ST_RETIRE;
                end
                ST_RETIRE: if (mem_ack) begin
                    evt_txbuf   <= 1'b1;
                    evt_txframe <= flags_q[FLG_LAST];
                    dcnt_q      <= dcnt_q + 1'b1;
                    state_q     <= (dcnt_q + 1'b1 == DCNT_W'(MAX_DESC)) ? ST_IDLE : ST_HDR;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    txr_ring_ptr #(.AW(AW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .step       (step),
        .step_wrap  (flags_q[FLG_WRAP]),
        .ring_base  (ring_base),
        .cur_ptr    (cur_ptr)
    );

    txr_word_cache #(.AW(AW)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .inval     (inval),
        .fill      (fill),
        .fill_addr (mem_addr),
        .fill_data (mem_rdata),
        .look_addr (byte_addr),
        .hit       (hit),
        .byte_out  (cache_byte)
    );

    txr_hold_stage u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (cache_byte),
        .in_ready  (in_ready),
        .close_req (close_req),
        .close_ack (close_ack),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready)
    );

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R6
    frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt_q <= FCNT_W'(FRAME_CAP));

    // R7
    desc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt_q <= DCNT_W'(MAX_DESC));

    // R8
    kick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !pend_q && !enable |=> (state_q == ST_IDLE));

    // R4
    retire_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_txframe |-> evt_txbuf);
endmodule

// File: tb/txring_engine_test.sv
// Testbench: scoreboard for the transmit ring walker.
// The driver task builds descriptors in a bench memory and queues the bytes it expects.
// A monitor pops the queue and compares each byte as the design sends it.
module txring_engine_test;
    localparam int CLK_P = 10;
    localparam int CAP   = 2032;
    localparam int LIMIT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        kick = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic [31:0] ring_base, cur_ptr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        evt_txbuf, evt_txframe, evt_babble;

    always #(CLK_P/2) clk = ~clk;

    txring_engine #(.FRAME_CAP(CAP), .MAX_DESC(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick),
        .base_we(base_we), .base_wdata(base_wdata),
        .ring_base(ring_base), .cur_ptr(cur_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready),
        .evt_txbuf(evt_txbuf), .evt_txframe(evt_txframe), .evt_babble(evt_babble)
    );

    logic [31:0] mem [4096];
    logic [8:0]  exp_q [$];
    int checks = 0, fails = 0;
    int n_buf = 0, n_frame = 0, n_bab = 0;
    int x_buf = 0, x_frame = 0, x_bab = 0;
    int x_fcnt = 0, x_fbytes = 0;
    int n_req = 0;
    int watch_addr = -1, watch_cnt = 0;
    bit rdy_rand = 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic void put_byte(input int a, input logic [7:0] b);
        mem[a[13:2]][31-8*a[1:0] -: 8] = b;
    endfunction

    // Driver: writes one descriptor and its buffer, and queues the expected bytes (R1, R3, R6).
    task automatic add_desc(input int a, input bit wrap, input bit last,
                            input int len, input int buf_a, input int seed);
        int take;
        logic [15:0] fl;
        fl = 16'h8000 | (wrap ? 16'h2000 : 16'h0) | (last ? 16'h0800 : 16'h0);
        mem[a[13:2]]       = {fl, 16'(len)};
        mem[a[13:2] + 1]   = buf_a;
        take = (len > CAP - x_fcnt) ? CAP - x_fcnt : len;
        if (len > CAP - x_fcnt) x_bab++;
        for (int i = 0; i < len; i++) begin
            put_byte(buf_a + i, 8'(seed + i));
            if (i < take) exp_q.push_back({1'b0, 8'(seed + i)});
        end
        x_fcnt += take;
        x_fbytes += take;
        x_buf++;
        if (last) begin
            if (x_fbytes > 0) exp_q[exp_q.size()-1][8] = 1'b1;
            x_fcnt = 0;
            x_fbytes = 0;
            x_frame++;
        end
    endtask

    // Memory responder: random latency; reads return big-endian words, writes update the bench memory.
    always @(negedge clk) begin
        if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req && ($urandom_range(0, 2) == 0)) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
            else begin
                mem_rdata <= mem[mem_addr[13:2]];
                if (int'(mem_addr) == watch_addr) watch_cnt++;
            end
        end
    end

    // Monitor: random sink readiness, byte comparison and event counting.
    always @(negedge clk) begin
        if (rst_n) begin
            if ($rose(mem_req)) n_req++;
            if (evt_txbuf) n_buf++;
            if (evt_txframe) n_frame++;
            if (evt_babble) n_bab++;
            tx_ready = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) chk(0, "R3", "unexpected byte", {tx_last, tx_data}, 0);
                else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({tx_last, tx_data} == e, "R3", "stream byte", {tx_last, tx_data}, e);
                end
            end
        end
    end

    task automatic pulse_kick();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 30) begin
            @(negedge clk);
            if (!mem_req && !tx_valid) q++; else q = 0;
        end
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk) begin base_we = 1'b1; base_wdata = v; end
        @(negedge clk) base_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int b0, f0, k0;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!tx_valid && !mem_req, "R10", "outputs idle in reset", {tx_valid, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cur_ptr == 0 && ring_base == 0, "R9", "pointer after reset", cur_ptr, 0);

        // R9: unaligned base write
        set_base(32'h103);
        @(negedge clk);
        chk(ring_base == 32'h100, "R9", "base aligned", ring_base, 32'h100);
        chk(cur_ptr == 32'h100, "R9", "pointer reloaded", cur_ptr, 32'h100);

        // R8: kick with the controller disabled
        add_desc(32'h100, 0, 1, 5, 32'h1000, 8'h10);
        k0 = n_req;
        pulse_kick();
        repeat (40) @(negedge clk);
        chk(n_req == k0, "R8", "memory requests", n_req - k0, 0);
        chk(cur_ptr == 32'h100, "R8", "pointer unchanged", cur_ptr, 32'h100);
        chk(mem[32'h100 >> 2][31], "R8", "descriptor still ready", mem[32'h100 >> 2], 1);

        // Single-buffer frame; the sentinel at 0x108 is not ready (R2, R4)
        enable = 1'b1;
        watch_addr = 32'h108; watch_cnt = 0;
        b0 = n_buf; f0 = n_frame;
        pulse_kick();
        wait_quiet();
        chk(cur_ptr == 32'h108, "R2", "stop at not-ready", cur_ptr, 32'h108);
        chk(mem[32'h100 >> 2] == 32'h0800_0005, "R4", "write-back word", mem[32'h100 >> 2], 32'h0800_0005);
        chk(mem[32'h108 >> 2] == 0, "R2", "no write-back at stop", mem[32'h108 >> 2], 0);
        chk(n_buf - b0 == 1 && n_frame - f0 == 1, "R4", "event counts", n_buf - b0, 1);
        chk(watch_cnt == 1, "R11", "single pass header reads", watch_cnt, 1);

        // Chain: unaligned buffers, zero-length middle, wrap on the last (R1, R3, R5)
        add_desc(32'h108, 0, 0, 3, 32'h1101, 8'h40);
        add_desc(32'h110, 0, 0, 0, 32'h1200, 8'h50);
        add_desc(32'h118, 1, 1, 4, 32'h1302, 8'h60);
        b0 = n_buf;
        pulse_kick();
        wait_quiet();
        chk(cur_ptr == 32'h100, "R5", "wrap to base", cur_ptr, 32'h100);
        chk(mem[32'h110 >> 2] == 32'h0000_0000, "R4", "zero-length write-back", mem[32'h110 >> 2], 0);
        chk(mem[32'h118 >> 2] == 32'h2800_0004, "R5", "wrap flag kept", mem[32'h118 >> 2], 32'h2800_0004);
        chk(n_buf - b0 == 3, "R4", "three buffers retired", n_buf - b0, 3);

        // Frame crossing the byte cap (R6)
        set_base(32'h200);
        add_desc(32'h200, 0, 0, 1500, 32'h1000, 8'h01);
        add_desc(32'h208, 0, 1, 1000, 32'h2000, 8'h80);
        k0 = n_bab;
        pulse_kick();
        wait_quiet();
        chk(n_bab - k0 == 1, "R6", "babble pulses", n_bab - k0, 1);
        chk(cur_ptr == 32'h210, "R6", "pointer after clipped frame", cur_ptr, 32'h210);

        // Per-kick descriptor limit (R7)
        set_base(32'h400);
        for (int i = 0; i < 8; i++) add_desc(32'h400 + 8*i, i == 7, 1, 1, 32'h3000 + 4*i, 8'hA0 + i);
        b0 = n_buf;
        pulse_kick();
        wait_quiet();
        chk(n_buf - b0 == LIMIT, "R7", "retired in first kick", n_buf - b0, LIMIT);
        chk(cur_ptr == 32'h400 + 8*LIMIT, "R7", "pointer after limit", cur_ptr, 32'h400 + 8*LIMIT);
        chk(mem[(32'h400 + 8*LIMIT) >> 2][31], "R7", "next still ready", 0, 1);
        b0 = n_buf;
        pulse_kick();
        wait_quiet();
        chk(n_buf - b0 == 8 - LIMIT, "R7", "retired in second kick", n_buf - b0, 8 - LIMIT);
        chk(cur_ptr == 32'h400, "R5", "ring wrapped", cur_ptr, 32'h400);

        // Kick while busy (R11)
        set_base(32'h300);
        add_desc(32'h300, 0, 1, 40, 32'h3100, 8'hC0);
        watch_addr = 32'h308; watch_cnt = 0;
        pulse_kick();
        repeat (3) @(negedge clk);
        pulse_kick();
        wait_quiet();
        chk(watch_cnt == 2, "R11", "latched kick reruns", watch_cnt, 2);

        rdy_rand = 1'b0;
        wait_quiet();
        chk(exp_q.size() == 0, "R3", "all bytes delivered", exp_q.size(), 0);
        chk(n_buf == x_buf && n_frame == x_frame, "R4", "total events", n_frame, x_frame);
        chk(n_bab == x_bab, "R6", "total babble", n_bab, x_bab);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule